// File: doc/BRIEF.md
# Thermal Sensor Current Scale-Back Controller

This block decides how a bank of LED current outputs reacts to over-temperature conditions. Two thermistor monitors each supply a digitized 4-bit voltage code. A monitor trips when it is enabled and its code drops below a programmable 4-bit setpoint: a falling thermistor voltage means a rising temperature. Setpoint code 0 stands for 250 mV and code 15 for 1 V, in 50 mV steps. A third source, the internal thermal scale-back indication, acts on every output at once when its enable is set.

Each source has a 2-bit action code. The code selects shutdown, a fallback to torch current, or report only. A per-output assignment mask chooses which outputs follow each monitor. When several active sources reach one output, the most severe action wins. The block stores the drive code of each output at the moment that output is first drawn into an event. It also keeps sticky flags that a read strobe clears. The registers that hold the configuration sit outside this block. For the scale-back path they reset to force-torch with the enable set.

Every input is a level that the block samples on each clock, and every output is a registered level, so the block has no back-pressure. A new input pattern shows up on the outputs one clock edge after it is sampled.

Top module: `therm_sb_ctrl`

## Requirements
- R1: After reset, every override command is none (2'b00), every held code is 0 and every flag is 0.
- R2: Monitor n trips only when its enable bit (mon_en_i[n]) is 1 and its reading is strictly less than its setpoint. An equal or higher reading does not trip, and a disabled monitor never trips.
- R3: Action code 2'b00 drives override 2'b10 (shutdown). Code 2'b01 drives override 2'b01 (torch). Codes 2'b10 and 2'b11 leave the override at 2'b00 (report only).
- R4: Bit i of mon_map_i assigns output i to monitor 1, and bit 4+i assigns output i to monitor 2. An output that is not assigned ignores that monitor.
- R5: When an output has more than one active source, shutdown wins over torch, and torch wins over report.
- R6: The scale-back event applies its own action code to every output when sb_en_i is 1. When sb_en_i is 0 the event is ignored.
- R7: When output i changes from no active source to at least one active source, of any action, held_code_o for output i loads that output's drive code from the same clock edge. The held code keeps that value until the next such change.
- R8: flag_o bit 0 (monitor 1 trip), bit 1 (monitor 2 trip) and bit 2 (scale-back event) set on an event and stay set while no read strobe arrives.
- R9: A read strobe clears all flags on the next edge. An event that arrives in the same cycle as the strobe still sets its flag.
- R10: Override commands, held codes and flags update on the first clock edge after the inputs that cause them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| therm_code_i | input | 8 | Thermistor readings, 4 bits per monitor, monitor 1 in the low nibble |
| trip_code_i | input | 8 | Trip setpoints, 4 bits per monitor, monitor 1 in the low nibble |
| mon_act_i | input | 4 | Action codes, 2 bits per monitor, monitor 1 in the low bits |
| mon_en_i | input | 2 | Monitor enables |
| mon_map_i | input | 8 | Output assignment mask, monitor 1 in the low nibble |
| sb_event_i | input | 1 | Internal thermal scale-back indication |
| sb_act_i | input | 2 | Scale-back action code |
| sb_en_i | input | 1 | Scale-back enable |
| drive_code_i | input | 32 | Active current code per output, 8 bits each, output 0 in the low byte |
| flag_rd_i | input | 1 | Flag read strobe, clears the sticky flags |
| ovr_cmd_o | output | 8 | Override command per output, 2 bits each: 00 none, 01 torch, 10 shutdown |
| held_code_o | output | 32 | Held current code per output, 8 bits each |
| flag_o | output | 3 | Sticky flags: monitor 1, monitor 2, scale-back |

## Verification
The hardest case to reach is the capture rule. The held code has to load only at the start of an involvement and stay frozen while the drive code keeps moving underneath it. The stimulus resets the block, asserts a monitor event while one drive code is applied, and then changes that drive code while the event is still held. It then releases the event and raises it again with a third code. A flag event placed in the same cycle as the read strobe covers the set-over-clear case.

// File: rtl/therm_sb_pkg.sv
package therm_sb_pkg;

  typedef enum logic [1:0] {
    OVR_NONE  = 2'b00,
    OVR_TORCH = 2'b01,
    OVR_SHUT  = 2'b10
  } ovr_e;

  function automatic ovr_e act_to_ovr(input logic [1:0] act);
    case (act)
      2'b00:   act_to_ovr = OVR_SHUT;
      2'b01:   act_to_ovr = OVR_TORCH;
      default: act_to_ovr = OVR_NONE;
    endcase
  endfunction

  function automatic ovr_e ovr_max(input ovr_e a, input ovr_e b);
    if (a == OVR_SHUT || b == OVR_SHUT)        ovr_max = OVR_SHUT;
    else if (a == OVR_TORCH || b == OVR_TORCH) ovr_max = OVR_TORCH;
    else                                       ovr_max = OVR_NONE;
  endfunction

endpackage

// File: rtl/tsc_monitor.sv
module tsc_monitor #(
  parameter int CW = 4
) (
  input  logic [CW-1:0] reading_i,
  input  logic [CW-1:0] setpoint_i,
  input  logic          enable_i,
  output logic          hit_o
);
  // lower voltage means hotter: trip strictly below the setpoint
  always_comb hit_o = enable_i && (reading_i < setpoint_i);
endmodule

// File: rtl/tsc_resolve.sv
module tsc_resolve
  import therm_sb_pkg::*;
#(
  parameter int NMON = 2,
  parameter int NOUT = 4
) (
  input  logic [NMON-1:0]      hit_i,
  input  logic [NMON*2-1:0]    act_i,
  input  logic [NMON*NOUT-1:0] map_i,
  input  logic                 sb_hit_i,
  input  logic [1:0]           sb_act_i,
  output logic [NOUT*2-1:0]    ovr_next_o,
  output logic [NOUT-1:0]      involved_o
);
  for (genvar o = 0; o < NOUT; o++) begin : g_out
    ovr_e cmd;
    logic inv;
    always_comb begin
      cmd = OVR_NONE;
      inv = 1'b0;
      for (int m = 0; m < NMON; m++) begin
        if (hit_i[m] && map_i[m*NOUT+o]) begin
          cmd = ovr_max(cmd, act_to_ovr(act_i[m*2 +: 2]));
          inv = 1'b1;
        end
      end
      if (sb_hit_i) begin
        cmd = ovr_max(cmd, act_to_ovr(sb_act_i));
        inv = 1'b1;
      end
    end
    assign ovr_next_o[o*2 +: 2] = cmd;
    assign involved_o[o]        = inv;
  end
endmodule

// File: rtl/tsc_capture.sv
module tsc_capture #(
  parameter int IW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          involved_i,
  input  logic [IW-1:0] drive_i,
  output logic [IW-1:0] held_o
);
  logic involved_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      involved_q <= 1'b0;
      held_o     <= '0;
    end else begin
      involved_q <= involved_i;
      if (involved_i && !involved_q) held_o <= drive_i;
    end
  end
endmodule

// File: rtl/therm_sb_ctrl.sv
module therm_sb_ctrl #(
  parameter int NMON = 2,
  parameter int NOUT = 4,
  parameter int CW   = 4,
  parameter int IW   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NMON*CW-1:0]   therm_code_i,
  input  logic [NMON*CW-1:0]   trip_code_i,
  input  logic [NMON*2-1:0]    mon_act_i,
  input  logic [NMON-1:0]      mon_en_i,
  input  logic [NMON*NOUT-1:0] mon_map_i,
  input  logic                 sb_event_i,
  input  logic [1:0]           sb_act_i,
  input  logic                 sb_en_i,
  input  logic [NOUT*IW-1:0]   drive_code_i,
  input  logic                 flag_rd_i,
  output logic [NOUT*2-1:0]    ovr_cmd_o,
  output logic [NOUT*IW-1:0]   held_code_o,
  output logic [NMON:0]        flag_o
);
  localparam int NFLAG = NMON + 1;

  logic [NMON-1:0]   hit;
  logic              sb_hit;
  logic [NOUT*2-1:0] ovr_next;
  logic [NOUT-1:0]   involved;

  for (genvar m = 0; m < NMON; m++) begin : g_mon
    tsc_monitor #(.CW(CW)) u_mon (
      .reading_i (therm_code_i[m*CW +: CW]),
      .setpoint_i(trip_code_i[m*CW +: CW]),
      .enable_i  (mon_en_i[m]),
      .hit_o     (hit[m])
    );
  end

  assign sb_hit = sb_en_i && sb_event_i;

  tsc_resolve #(.NMON(NMON), .NOUT(NOUT)) u_res (
    .hit_i     (hit),
    .act_i     (mon_act_i),
    .map_i     (mon_map_i),
    .sb_hit_i  (sb_hit),
    .sb_act_i  (sb_act_i),
    .ovr_next_o(ovr_next),
    .involved_o(involved)
  );

  for (genvar o = 0; o < NOUT; o++) begin : g_cap
    tsc_capture #(.IW(IW)) u_cap (
      .clk       (clk),
      .rst_n     (rst_n),
      .involved_i(involved[o]),
      .drive_i   (drive_code_i[o*IW +: IW]),
      .held_o    (held_code_o[o*IW +: IW])
    );
  end

  logic [NFLAG-1:0] flag_evt;
  assign flag_evt = {sb_hit, hit};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_cmd_o <= '0;
      flag_o    <= '0;
    end else begin
      ovr_cmd_o <= ovr_next;
      flag_o    <= (flag_rd_i ? '0 : flag_o) | flag_evt;
    end
  end
endmodule

// File: rtl/therm_sb_chk.sv
module therm_sb_chk #(
  parameter int NMON = 2,
  parameter int NOUT = 4,
  parameter int IW   = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NMON-1:0]      mon_en_i,
  input logic                 sb_en_i,
  input logic                 flag_rd_i,
  input logic [NOUT*2-1:0]    ovr_cmd_o,
  input logic [NOUT*IW-1:0]   held_code_o,
  input logic [NMON:0]        flag_o
);
  logic quiet;
  assign quiet = (mon_en_i == '0) && !sb_en_i;

  for (genvar o = 0; o < NOUT; o++) begin : g_legal
    AST_CMD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_cmd_o[o*2 +: 2] != 2'b11); // R3
  end

  for (genvar k = 0; k <= NMON; k++) begin : g_sticky
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o[k] && !flag_rd_i) |=> flag_o[k]); // R8
  end

  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_rd_i && quiet) |=> (flag_o == '0)); // R9

  AST_QUIET_NO_OVR: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |=> (ovr_cmd_o == '0)); // R6

  AST_QUIET_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |=> $stable(held_code_o)); // R7
endmodule

bind therm_sb_ctrl therm_sb_chk #(.NMON(NMON), .NOUT(NOUT), .IW(IW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mon_en_i   (mon_en_i),
  .sb_en_i    (sb_en_i),
  .flag_rd_i  (flag_rd_i),
  .ovr_cmd_o  (ovr_cmd_o),
  .held_code_o(held_code_o),
  .flag_o     (flag_o)
);

// File: tb/therm_sb_ctrl_tb.sv
module therm_sb_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  therm_code_i = '0;
  logic [7:0]  trip_code_i = '0;
  logic [3:0]  mon_act_i = '0;
  logic [1:0]  mon_en_i = '0;
  logic [7:0]  mon_map_i = '0;
  logic        sb_event_i = 1'b0;
  logic [1:0]  sb_act_i = '0;
  logic        sb_en_i = 1'b0;
  logic [31:0] drive_code_i = '0;
  logic        flag_rd_i = 1'b0;
  logic [7:0]  ovr_cmd_o;
  logic [31:0] held_code_o;
  logic [2:0]  flag_o;

  int n_chk = 0;
  int n_bad = 0;

  always #10ns clk = ~clk;

  therm_sb_ctrl u_dut (.*);

  typedef struct packed {
    logic [3:0] rd1, set1, rd2, set2;
    logic [1:0] m1, m2, en;
    logic [7:0] map;
    logic       tin;
    logic [1:0] tact;
    logic       ten;
    logic [7:0] exp;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{4'd5, 4'd8, 4'd15,4'd0, 2'b00,2'b00,2'b01,8'h01,1'b0,2'b00,1'b0,8'h02}, // R2 R3 R4 shutdown
    '{4'd8, 4'd8, 4'd15,4'd0, 2'b00,2'b00,2'b01,8'h01,1'b0,2'b00,1'b0,8'h00}, // R2 equal
    '{4'd3, 4'd8, 4'd15,4'd0, 2'b00,2'b00,2'b00,8'h01,1'b0,2'b00,1'b0,8'h00}, // R2 disabled
    '{4'd3, 4'd8, 4'd15,4'd0, 2'b01,2'b00,2'b01,8'h05,1'b0,2'b00,1'b0,8'h11}, // R3 torch
    '{4'd3, 4'd8, 4'd15,4'd0, 2'b10,2'b00,2'b01,8'h0F,1'b0,2'b00,1'b0,8'h00}, // R3 report
    '{4'd3, 4'd8, 4'd15,4'd0, 2'b11,2'b00,2'b01,8'h0F,1'b0,2'b00,1'b0,8'h00}, // R3 report
    '{4'd15,4'd0, 4'd2, 4'd10,2'b00,2'b00,2'b10,8'hC0,1'b0,2'b00,1'b0,8'hA0}, // R4 monitor 2
    '{4'd3, 4'd8, 4'd2, 4'd10,2'b01,2'b00,2'b11,8'h23,1'b0,2'b00,1'b0,8'h09}, // R5
    '{4'd3, 4'd8, 4'd2, 4'd10,2'b10,2'b01,2'b11,8'hFF,1'b0,2'b00,1'b0,8'h55}, // R5
    '{4'd15,4'd0, 4'd15,4'd0, 2'b00,2'b00,2'b00,8'h00,1'b1,2'b01,1'b1,8'h55}, // R6 torch
    '{4'd15,4'd0, 4'd15,4'd0, 2'b00,2'b00,2'b00,8'h00,1'b1,2'b00,1'b1,8'hAA}, // R6 shutdown
    '{4'd15,4'd0, 4'd15,4'd0, 2'b00,2'b00,2'b00,8'h00,1'b1,2'b00,1'b0,8'h00}, // R6 disabled
    '{4'd3, 4'd8, 4'd15,4'd0, 2'b00,2'b00,2'b01,8'h08,1'b1,2'b01,1'b1,8'h95}, // R5 R6
    '{4'd0, 4'd1, 4'd15,4'd0, 2'b00,2'b00,2'b01,8'h01,1'b0,2'b00,1'b0,8'h02}, // R2 boundary
    '{4'd15,4'd0, 4'd2, 4'd10,2'b00,2'b00,2'b01,8'hF0,1'b0,2'b00,1'b0,8'h00}, // R2 mon2 off
    '{4'd15,4'd0, 4'd2, 4'd10,2'b00,2'b00,2'b10,8'h0F,1'b0,2'b00,1'b0,8'h00}  // R4 unmapped
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic quiet_inputs();
    mon_en_i = '0; sb_en_i = 1'b0; sb_event_i = 1'b0; flag_rd_i = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; quiet_inputs();
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected done");
    finish_run();
  end

  initial begin
    do_reset();
    check("R1 ovr", ovr_cmd_o, 0);
    check("R1 held", held_code_o, 0);
    check("R1 flag", flag_o, 0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      therm_code_i = {VEC[i].rd2, VEC[i].rd1};
      trip_code_i  = {VEC[i].set2, VEC[i].set1};
      mon_act_i    = {VEC[i].m2, VEC[i].m1};
      mon_en_i     = VEC[i].en;
      mon_map_i    = VEC[i].map;
      sb_event_i   = VEC[i].tin;
      sb_act_i     = VEC[i].tact;
      sb_en_i      = VEC[i].ten;
      @(negedge clk);
      check($sformatf("R10 vector %0d", i), ovr_cmd_o, VEC[i].exp);
    end

    // capture rule: R7
    do_reset();
    therm_code_i = 8'hF3; trip_code_i = 8'h08; mon_act_i = 4'b0010;
    mon_map_i = 8'h01; drive_code_i = 32'h4433_223C; mon_en_i = 2'b01;
    @(negedge clk);
    check("R7 first capture", held_code_o, 32'h0000_003C);
    drive_code_i = 32'h4433_2211;
    @(negedge clk);
    check("R7 held while involved", held_code_o, 32'h0000_003C);
    mon_en_i = 2'b00;
    @(negedge clk);
    drive_code_i = 32'h4433_2277; mon_en_i = 2'b01;
    @(negedge clk);
    check("R7 recapture", held_code_o, 32'h0000_0077);
    check("R8 mon1 flag", flag_o, 3'b001);

    // sticky and clear: R8 R9
    mon_en_i = 2'b00;
    sb_event_i = 1'b1; sb_en_i = 1'b1; sb_act_i = 2'b10;
    @(negedge clk);
    sb_event_i = 1'b0; sb_en_i = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R8 sticky", flag_o, 3'b101);
    check("R3 report leaves ovr", ovr_cmd_o, 8'h00);
    flag_rd_i = 1'b1;
    @(negedge clk);
    flag_rd_i = 1'b0;
    check("R9 clear", flag_o, 3'b000);
    flag_rd_i = 1'b1; therm_code_i = 8'h2F; trip_code_i = 8'hA0; mon_en_i = 2'b10;
    @(negedge clk);
    flag_rd_i = 1'b0; mon_en_i = 2'b00;
    check("R9 set wins", flag_o, 3'b010);

    finish_run();
  end
endmodule